// File: doc/BRIEF.md
# Decode Slot Template Allocator

This block sits between a queue of already-parsed instructions and four parallel decoders. Each cycle the queue presents up to four instructions at its head, oldest at position 0. Each one carries a payload and the number of micro-ops it expands into. The allocator chooses the longest run of leading instructions that fits the decode template. Only the first decode lane can take an instruction that expands to more than one micro-op, and that lane has a ceiling of `SLOT0_MAX_OPS`. The other three lanes take single-op instructions only. The chosen instructions are loaded into the slot registers.

The number taken is reported in the same cycle, so the queue can pop that many entries on the same clock edge. An instruction whose expansion exceeds the first lane's ceiling is a long instruction. It is placed alone in lane 0, marked for the micro-op sequencer, and allocation then freezes until the sequencer reports completion. When the downstream decoders are not ready, nothing is taken and the slot outputs keep their contents.

Top module: `slot_alloc_top`

## Requirements
- R1: Instructions go into slots in program order. Slot k holds the payload and micro-op count of input position k. Slot contents appear one clock after the edge at which they are taken.
- R2: Slot 0 accepts an instruction whose micro-op count is 1 to `SLOT0_MAX_OPS` (default 4) and marks it as not sequencer-bound.
- R3: Slots 1 to 3 accept only instructions with a micro-op count of exactly 1. A valid instruction at position 1 to 3 with any other count ends the group: neither it nor any later position is taken that cycle.
- R4: An invalid position ends the group. Valid positions after it are not taken.
- R5: An instruction at position 0 whose count exceeds `SLOT0_MAX_OPS` is taken alone. It appears in slot 0 with `slot0ToSeq` high, and the other slots are empty.
- R6: After a sequencer-bound instruction is taken, the take count stays 0 and the slots load empty. This lasts until the cycle after `seqDone` is sampled high.
- R7: `seqDone` has no effect when no sequencer-bound instruction is outstanding.
- R8: `takeCount` is combinational and ranges from 0 to 4. It equals the number of leading positions placed in the current cycle. It is 0 when position 0 is invalid.
- R9: When `dnReady` is low, `takeCount` is 0, the slot outputs keep their values and no sequencer handoff starts.
- R10: After reset all slots are empty, `slot0ToSeq` is low and no sequencer handoff is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 4 | Valid flag per queue head position, bit 0 oldest |
| inOps | input | 4*OPS_W | Micro-op count per position, position k at bits [k*OPS_W +: OPS_W] |
| inData | input | 4*DATA_W | Instruction payload per position, position k at bits [k*DATA_W +: DATA_W] |
| dnReady | input | 1 | Decoders can accept a new slot group |
| seqDone | input | 1 | Sequencer has finished the long instruction |
| takeCount | output | 3 | Number of leading positions taken this cycle |
| slotValid | output | 4 | Slot occupied flags |
| slotOps | output | 4*OPS_W | Micro-op count per slot |
| slotData | output | 4*DATA_W | Payload per slot |
| slot0ToSeq | output | 1 | Slot 0 holds a sequencer-bound instruction |

## Verification
`takeCount` is due in the same cycle as the inputs that produce it. The bench drives its inputs at the falling edge and samples `takeCount` one nanosecond later, before the next rising edge. Slot valid flags, payloads, counts and the sequencer flag are due one rising edge later. The bench samples them one nanosecond after that edge, before it drives the next inputs. The sequencer freeze is checked cycle by cycle: the take count is observed in the cycle `seqDone` is raised and again in the cycle after it.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  // The decode template is four lanes wide; lane 0 is the complex lane.
  localparam int SLOTS = 4;
  localparam int CNT_W = $clog2(SLOTS + 1);

  // Strobes from control to datapath.
  typedef struct packed {
    logic             load;       // update slot registers this edge
    logic             toSeq;      // lane 0 carries a sequencer-bound instruction
    logic [SLOTS-1:0] placeMask;  // positions placed this cycle
  } allocStrobe_t;
endpackage

// File: rtl/slot_alloc_ctrl.sv
module slot_alloc_ctrl
  import slot_alloc_pkg::*;
#(
  parameter int OPS_W         = 4,
  parameter int SLOT0_MAX_OPS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLOTS-1:0]       inValid,
  input  logic [SLOTS*OPS_W-1:0] inOps,
  input  logic                   dnReady,
  input  logic                   seqDone,
  output allocStrobe_t           strobe,
  output logic [CNT_W-1:0]       takeCount
);
  localparam logic [OPS_W-1:0] OPS_ONE   = OPS_W'(1);
  localparam logic [OPS_W-1:0] OPS_LIMIT = OPS_W'(SLOT0_MAX_OPS);

  logic             seqBusy;
  logic [SLOTS-1:0] placeMask;
  logic             toSeq;

  // In-order packing: lane 0 takes any count, long ones go alone to the
  // sequencer; later lanes extend the run only with single-op entries.
  always_comb begin
    placeMask = '0;
    toSeq     = 1'b0;
    if (dnReady && !seqBusy && inValid[0]) begin
      placeMask[0] = 1'b1;
      if (inOps[OPS_W-1:0] > OPS_LIMIT) begin
        toSeq = 1'b1;
      end else begin
        for (int k = 1; k < SLOTS; k++) begin
          if (placeMask[k-1] && inValid[k] && (inOps[k*OPS_W +: OPS_W] == OPS_ONE))
            placeMask[k] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 seqBusy <= 1'b0;
    else if (dnReady && toSeq)  seqBusy <= 1'b1;
    else if (seqDone)           seqBusy <= 1'b0;
  end

  assign strobe.load      = dnReady;
  assign strobe.toSeq     = toSeq;
  assign strobe.placeMask = placeMask;
  assign takeCount        = CNT_W'($countones(placeMask));

  AST_BUSY_TAKES_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    seqBusy |-> (takeCount == '0)); // R6
  AST_STALL_TAKES_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !dnReady |-> (takeCount == '0)); // R9
  AST_SEQ_TAKEN_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.toSeq |-> (takeCount == CNT_W'(1))); // R5
  AST_PREFIX_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((placeMask & (placeMask + 1'b1)) == '0)); // R8
endmodule

// File: rtl/slot_alloc_dpath.sv
module slot_alloc_dpath
  import slot_alloc_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int OPS_W         = 4,
  parameter int SLOT0_MAX_OPS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  allocStrobe_t            strobe,
  input  logic [SLOTS*OPS_W-1:0]  inOps,
  input  logic [SLOTS*DATA_W-1:0] inData,
  output logic [SLOTS-1:0]        slotValid,
  output logic [SLOTS*OPS_W-1:0]  slotOps,
  output logic [SLOTS*DATA_W-1:0] slotData,
  output logic                    slot0ToSeq
);
  localparam logic [OPS_W-1:0] OPS_ONE   = OPS_W'(1);
  localparam logic [OPS_W-1:0] OPS_LIMIT = OPS_W'(SLOT0_MAX_OPS);

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slotValid[g]                  <= 1'b0;
        slotOps[g*OPS_W +: OPS_W]     <= '0;
        slotData[g*DATA_W +: DATA_W]  <= '0;
      end else if (strobe.load) begin
        slotValid[g] <= strobe.placeMask[g];
        if (strobe.placeMask[g]) begin
          slotOps[g*OPS_W +: OPS_W]    <= inOps[g*OPS_W +: OPS_W];
          slotData[g*DATA_W +: DATA_W] <= inData[g*DATA_W +: DATA_W];
        end
      end
    end

    if (g > 0) begin : gSimpleLane
      AST_SIMPLE_LANE_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        slotValid[g] |-> (slotOps[g*OPS_W +: OPS_W] == OPS_ONE)); // R3
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           slot0ToSeq <= 1'b0;
    else if (strobe.load) slot0ToSeq <= strobe.toSeq;
  end

  AST_LANE0_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (slotValid[0] && !slot0ToSeq) |-> (slotOps[OPS_W-1:0] <= OPS_LIMIT)); // R2
  AST_SEQ_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
    slot0ToSeq |-> (slotValid == SLOTS'(1))); // R5
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> ($stable(slotValid) && $stable(slotData) && $stable(slot0ToSeq))); // R9
endmodule

// File: rtl/slot_alloc_top.sv
module slot_alloc_top
  import slot_alloc_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int OPS_W         = 4,
  parameter int SLOT0_MAX_OPS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SLOTS-1:0]        inValid,
  input  logic [SLOTS*OPS_W-1:0]  inOps,
  input  logic [SLOTS*DATA_W-1:0] inData,
  input  logic                    dnReady,
  input  logic                    seqDone,
  output logic [CNT_W-1:0]        takeCount,
  output logic [SLOTS-1:0]        slotValid,
  output logic [SLOTS*OPS_W-1:0]  slotOps,
  output logic [SLOTS*DATA_W-1:0] slotData,
  output logic                    slot0ToSeq
);
  allocStrobe_t strobe;

  slot_alloc_ctrl #(.OPS_W(OPS_W), .SLOT0_MAX_OPS(SLOT0_MAX_OPS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inOps(inOps),
    .dnReady(dnReady), .seqDone(seqDone), .strobe(strobe), .takeCount(takeCount)
  );

  slot_alloc_dpath #(.DATA_W(DATA_W), .OPS_W(OPS_W), .SLOT0_MAX_OPS(SLOT0_MAX_OPS)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inOps(inOps), .inData(inData),
    .slotValid(slotValid), .slotOps(slotOps), .slotData(slotData), .slot0ToSeq(slot0ToSeq)
  );
endmodule

// File: tb/slot_alloc_top_tb_top.sv
module slot_alloc_top_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DATA_W = 16;
  localparam int OPS_W  = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [3:0]           inValid = '0;
  logic [4*OPS_W-1:0]   inOps = '0;
  logic [4*DATA_W-1:0]  inData = '0;
  logic                 dnReady = 1'b0;
  logic                 seqDone = 1'b0;
  logic [2:0]           takeCount;
  logic [3:0]           slotValid;
  logic [4*OPS_W-1:0]   slotOps;
  logic [4*DATA_W-1:0]  slotData;
  logic                 slot0ToSeq;

  int vectors = 0;
  int fails   = 0;

  always #2.5 clk = ~clk;

  slot_alloc_top #(.DATA_W(DATA_W), .OPS_W(OPS_W), .SLOT0_MAX_OPS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inOps(inOps), .inData(inData),
    .dnReady(dnReady), .seqDone(seqDone), .takeCount(takeCount), .slotValid(slotValid),
    .slotOps(slotOps), .slotData(slotData), .slot0ToSeq(slot0ToSeq)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, then check the same-cycle take count.
  task automatic step(input logic [3:0] v, input logic [OPS_W-1:0] o0, o1, o2, o3,
                      input logic [7:0] seed, input logic rdy, input logic done,
                      input int expTake, input string req);
    @(negedge clk);
    inValid = v;
    inOps   = {o3, o2, o1, o0};
    for (int k = 0; k < 4; k++) inData[k*DATA_W +: DATA_W] = {seed, 8'(k)};
    dnReady = rdy;
    seqDone = done;
    #1;
    chk(takeCount == 3'(expTake), req, "takeCount", int'(takeCount), expTake);
  endtask

  // Check slot registers one edge later against an expected payload vector.
  task automatic slots(input logic [3:0] expMask, input logic expSeq,
                       input logic [4*DATA_W-1:0] src, input string req);
    @(posedge clk);
    #1;
    chk(slotValid == expMask, req, "slotValid", int'(slotValid), int'(expMask));
    chk(slot0ToSeq == expSeq, req, "slot0ToSeq", int'(slot0ToSeq), int'(expSeq));
    for (int k = 0; k < 4; k++)
      if (expMask[k])
        chk(slotData[k*DATA_W +: DATA_W] == src[k*DATA_W +: DATA_W], req, "slotData",
            int'(slotData[k*DATA_W +: DATA_W]), int'(src[k*DATA_W +: DATA_W]));
  endtask

  task automatic testReset();
    #1;
    chk(slotValid == 4'b0, "R10", "slotValid", int'(slotValid), 0);
    chk(slot0ToSeq == 1'b0, "R10", "slot0ToSeq", int'(slot0ToSeq), 0);
    chk(takeCount == 3'd0, "R10", "takeCount", int'(takeCount), 0);
  endtask

  task automatic testAllSingle();  // R1 R8
    step(4'hF, 1, 1, 1, 1, 8'h10, 1, 0, 4, "R8");
    slots(4'hF, 0, inData, "R1");
  endtask

  task automatic testComplexFirst();  // R2
    step(4'hF, 4, 1, 1, 1, 8'h20, 1, 0, 4, "R2");
    slots(4'hF, 0, inData, "R2");
    chk(slotOps[OPS_W-1:0] == 4'd4, "R2", "slot0 ops", int'(slotOps[OPS_W-1:0]), 4);
  endtask

  task automatic testMidBreak();  // R3
    step(4'hF, 1, 1, 2, 1, 8'h30, 1, 0, 2, "R3");
    slots(4'b0011, 0, inData, "R3");
    step(4'hF, 2, 1, 1, 1, 8'h31, 1, 0, 4, "R3");
    slots(4'hF, 0, inData, "R3");
    step(4'hF, 3, 5, 1, 1, 8'h32, 1, 0, 1, "R3");
    slots(4'b0001, 0, inData, "R3");
  endtask

  task automatic testGap();  // R4 R8
    step(4'b1101, 1, 1, 1, 1, 8'h40, 1, 0, 1, "R4");
    slots(4'b0001, 0, inData, "R4");
    step(4'b1110, 1, 1, 1, 1, 8'h41, 1, 0, 0, "R8");
    slots(4'b0000, 0, inData, "R8");
  endtask

  task automatic testSequencer();  // R5 R6
    step(4'hF, 5, 1, 1, 1, 8'h50, 1, 0, 1, "R5");
    slots(4'b0001, 1, inData, "R5");
    chk(slotOps[OPS_W-1:0] == 4'd5, "R5", "slot0 ops", int'(slotOps[OPS_W-1:0]), 5);
    step(4'hF, 1, 1, 1, 1, 8'h51, 1, 0, 0, "R6");
    slots(4'b0000, 0, inData, "R6");
    step(4'hF, 1, 1, 1, 1, 8'h52, 1, 1, 0, "R6");
    slots(4'b0000, 0, inData, "R6");
    step(4'hF, 1, 1, 1, 1, 8'h53, 1, 0, 4, "R6");
    slots(4'hF, 0, inData, "R6");
  endtask

  task automatic testIdleDone();  // R7
    step(4'hF, 1, 1, 1, 1, 8'h60, 1, 1, 4, "R7");
    slots(4'hF, 0, inData, "R7");
    step(4'hF, 1, 1, 1, 1, 8'h61, 1, 0, 4, "R7");
    slots(4'hF, 0, inData, "R7");
  endtask

  task automatic testStall();  // R9
    logic [4*DATA_W-1:0] held;
    step(4'hF, 1, 1, 1, 1, 8'h70, 1, 0, 4, "R9");
    slots(4'hF, 0, inData, "R9");
    held = inData;
    step(4'hF, 1, 1, 1, 1, 8'h71, 0, 0, 0, "R9");
    slots(4'hF, 0, held, "R9");
    step(4'hF, 7, 1, 1, 1, 8'h72, 0, 0, 0, "R9");
    slots(4'hF, 0, held, "R9");
    step(4'hF, 1, 1, 1, 1, 8'h73, 1, 0, 4, "R9");
    slots(4'hF, 0, inData, "R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testAllSingle();
    testComplexFirst();
    testMidBreak();
    testGap();
    testSequencer();
    testIdleDone();
    testStall();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule